// File: doc/BRIEF.md
# Event-Driven Column Address Capture

This block sits at the foot of one column of single-photon pixels. All pixels in the column share one active-low event line and one active-low binary address bus. Both idle high. A pixel that detects a photon pulls the event line low and pulls low the address bits that encode its own row index. The block brings the event line and the address bus into the system clock domain. It sees the first low level after a high period and then waits a programmable number of clock cycles. This wait stands in for matching the setup time of the address latch. After the wait it stores the inverted bus as a true row index and gives a one-cycle valid strobe to the downstream readout.

After a capture the block takes no further event until the event line has gone high again. A pixel that fires while the line is still low from an earlier photon is therefore lost. The stored address stays put until the next capture. The block also drives the column's active-low recharge enable. When the enable is withdrawn the column waits and no event is taken. Downstream acknowledges each strobe. A new capture that arrives before the acknowledge sets a sticky overflow flag.

Top module: `colcap_top`

## Requirements
- R1: After reset, cap_valid is 0, cap_addr is 0, overflow is 0 and recharge_n is 1.
- R2: recharge_n equals the inverse of run_en as sampled on the previous rising clock edge (run_en=1 gives recharge_n=0).
- R3: If the first rising edge that samples evt_line_n low is edge E, then cap_valid is 1 in the cycle that follows edge E+3+D. Here D is the value of cfg_delay (4 bits, 0..15), held stable during the event.
- R4: The captured cap_addr is the bitwise inverse of addr_bus_n as held during the event. A pixel with row index k drives addr_bus_n = ~k over 7 bits.
- R5: cap_valid is high for exactly one cycle per capture.
- R6: While evt_line_n stays low after a capture, changes on addr_bus_n produce no strobe and leave cap_addr unchanged. A high level of evt_line_n for a single clock cycle re-arms the block, and the next low level is captured.
- R7: While run_en is 0 (recharge_n high), a low pulse on evt_line_n produces no strobe and leaves cap_addr unchanged.
- R8: A capture while the previous capture has not been acknowledged sets overflow. Such a capture is one where no ack=1 pulse was sampled on a rising edge after the previous strobe, up to and including the current one. overflow stays 1 until reset. Captures that are each acknowledged leave overflow at 0.
- R9: cap_addr changes only on the edge that raises cap_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Column run request; 1 enables recharge and capture |
| cfg_delay | input | 4 | Capture wait in clock cycles after detection |
| evt_line_n | input | 1 | Shared active-low pixel event line, asynchronous |
| addr_bus_n | input | 7 | Shared active-low pixel address bus, asynchronous |
| ack | input | 1 | Downstream acknowledge of the last strobe |
| recharge_n | output | 1 | Active-low column recharge enable |
| cap_valid | output | 1 | One-cycle strobe for a captured address |
| cap_addr | output | 7 | Last captured row index |
| overflow | output | 1 | Sticky flag for a capture that overran an unacknowledged one |

## Verification
The bench checks the exact strobe cycle at the two ends of the delay range (0 and 15) and at a middle value. A design off by one in its synchronizer or its counter would strobe a cycle early or late. The bench drives a second pixel after a capture while the line is still low, and also pulses the line while the column is disabled. A design that re-triggered on a level, or ignored the run request, would give an extra strobe or overwrite the held address. A one-cycle high gap between events checks re-arming, which a design that demanded a longer high period would miss. The bench also checks that overflow is set only by an unacknowledged capture and that it stays set, so a flag that self-cleared or was set by an acknowledged capture would be caught.

// File: rtl/colcap_pkg.sv
package colcap_pkg;

    // Capture sequencer state
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } cap_state_e;

endpackage

// File: rtl/colcap_sync.sv
// Multi-stage synchronizer for asynchronous, slowly changing pixel lines.
module colcap_sync #(
    parameter int          WIDTH   = 1,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= RST_VAL;
                end else begin
                    stage_q[g] <= stage_d[g];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/colcap_ctrl.sv
// Arming, event acceptance and programmable capture wait.
module colcap_ctrl
    import colcap_pkg::*;
#(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_s,     // synchronized event line, active low
    input  logic             run,        // column enabled
    input  logic [DLY_W-1:0] cfg_delay,
    output logic             fire        // latch the address this edge
);

    typedef struct packed {
        cap_state_e       st;
        logic [DLY_W-1:0] cnt;
        logic             armed;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        fire   = 1'b0;
        if (line_s) begin
            ctrl_d.armed = 1'b1;
        end
        unique case (ctrl_q.st)
            ST_IDLE: begin
                if (run && ctrl_q.armed && !line_s) begin
                    ctrl_d.st    = ST_WAIT;
                    ctrl_d.cnt   = cfg_delay;
                    ctrl_d.armed = 1'b0;
                end
            end
            ST_WAIT: begin
                if (ctrl_q.cnt == '0) begin
                    fire      = 1'b1;
                    ctrl_d.st = ST_IDLE;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt - 1'b1;
                end
            end
            default: ctrl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{st: ST_IDLE, cnt: '0, armed: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

endmodule

// File: rtl/colcap_out.sv
// Address latch, strobe and overrun tracking.
module colcap_out #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [ADDR_W-1:0] addr_s,    // synchronized bus, active low
    input  logic              ack,
    output logic              cap_valid,
    output logic [ADDR_W-1:0] cap_addr,
    output logic              overflow
);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic              pend;
        logic              ovf;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d       = out_q;
        out_d.valid = fire;
        if (fire) begin
            out_d.addr = ~addr_s;
            out_d.pend = 1'b1;
            if (out_q.pend && !ack) begin
                out_d.ovf = 1'b1;
            end
        end else if (ack) begin
            out_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign cap_valid = out_q.valid;
    assign cap_addr  = out_q.addr;
    assign overflow  = out_q.ovf;

endmodule

// File: rtl/colcap_top.sv
// End-of-column event capture for one column of photon pixels.
module colcap_top #(
    parameter int NROWS  = 112,
    parameter int DLY_W  = 4,
    parameter int SYNC_N = 2,
    localparam int ADDR_W = $clog2(NROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [DLY_W-1:0]  cfg_delay,
    input  logic              evt_line_n,
    input  logic [ADDR_W-1:0] addr_bus_n,
    input  logic              ack,
    output logic              recharge_n,
    output logic              cap_valid,
    output logic [ADDR_W-1:0] cap_addr,
    output logic              overflow
);

    logic              line_s;
    logic [ADDR_W-1:0] addr_s;
    logic              fire;
    logic              rch_d, rch_q;

    always_comb begin
        rch_d = ~run_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rch_q <= 1'b1;
        end else begin
            rch_q <= rch_d;
        end
    end

    assign recharge_n = rch_q;

    colcap_sync #(.WIDTH(1), .STAGES(SYNC_N), .RST_VAL(1'b1)) u_line_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (evt_line_n),
        .q     (line_s)
    );

    colcap_sync #(.WIDTH(ADDR_W), .STAGES(SYNC_N), .RST_VAL({ADDR_W{1'b1}})) u_addr_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (addr_bus_n),
        .q     (addr_s)
    );

    colcap_ctrl #(.DLY_W(DLY_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_s    (line_s),
        .run       (~rch_q),
        .cfg_delay (cfg_delay),
        .fire      (fire)
    );

    colcap_out #(.ADDR_W(ADDR_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .addr_s    (addr_s),
        .ack       (ack),
        .cap_valid (cap_valid),
        .cap_addr  (cap_addr),
        .overflow  (overflow)
    );

endmodule

// File: rtl/colcap_chk.sv
module colcap_chk #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic              recharge_n,
    input logic              cap_valid,
    input logic [ADDR_W-1:0] cap_addr,
    input logic              overflow
);

    AST_RECHARGE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (recharge_n == !$past(run_en)));                       // R2

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> !cap_valid);                                      // R5

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_valid |-> $stable(cap_addr));                              // R9

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);                                         // R8

    AST_OVF_WITH_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> cap_valid);                                 // R8

endmodule

bind colcap_top colcap_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .recharge_n (recharge_n),
    .cap_valid  (cap_valid),
    .cap_addr   (cap_addr),
    .overflow   (overflow)
);

// File: tb/colcap_top_bench.sv
`timescale 1ns/1ps
module colcap_top_bench;

    localparam int AW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_en = 1'b0;
    logic [3:0]    cfg_delay = 4'd0;
    logic          evt_line_n = 1'b1;
    logic [AW-1:0] addr_bus_n = '1;
    logic          ack = 1'b0;
    logic          recharge_n;
    logic          cap_valid;
    logic [AW-1:0] cap_addr;
    logic          overflow;

    typedef struct {
        logic [AW-1:0] addr;
        int            due;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   auto_ack = 1'b1;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    colcap_top u_colcap_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .cfg_delay  (cfg_delay),
        .evt_line_n (evt_line_n),
        .addr_bus_n (addr_bus_n),
        .ack        (ack),
        .recharge_n (recharge_n),
        .cap_valid  (cap_valid),
        .cap_addr   (cap_addr),
        .overflow   (overflow)
    );

    task automatic check(input string req, input int act, input int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Monitor: every strobe is popped against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            ack <= 1'b0;
            if (cap_valid) begin
                if (exp_q.size() == 0) begin
                    check("R6/R7 unexpected strobe", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check("R3 strobe cycle", cyc, e.due);
                    check("R4 captured address", int'(cap_addr), int'(e.addr));
                    if (auto_ack) ack <= 1'b1;
                end
            end
        end
    end

    // Driver: one pixel event; called at a negative edge
    task automatic fire(input logic [AW-1:0] a, input int hold, input int gap);
        exp_t e;
        e.addr = a;
        e.due  = cyc + 4 + int'(cfg_delay);
        exp_q.push_back(e);
        addr_bus_n = ~a;
        evt_line_n = 1'b0;
        repeat (hold) @(negedge clk);
        evt_line_n = 1'b1;
        addr_bus_n = '1;
        repeat (gap) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 cap_valid reset", int'(cap_valid), 0);
        check("R1 cap_addr reset", int'(cap_addr), 0);
        check("R1 overflow reset", int'(overflow), 0);
        check("R1 recharge_n reset", int'(recharge_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 recharge_n while idle", int'(recharge_n), 1);
        run_en = 1'b1;
        @(negedge clk);
        check("R2 recharge_n enabled", int'(recharge_n), 0);
        repeat (3) @(negedge clk);

        // R3 R4 R5 across delay values
        cfg_delay = 4'd0;  fire(7'd5,   8, 6);
        cfg_delay = 4'd15; fire(7'd111, 24, 6);
        cfg_delay = 4'd7;  fire(7'd0,   14, 6);
        cfg_delay = 4'd2;  fire(7'd127, 10, 6);
        check("R8 no overflow when acked", int'(overflow), 0);

        // R6 collision: second pixel while line still low
        cfg_delay = 4'd3;
        begin
            exp_t e;
            e.addr = 7'd42;
            e.due  = cyc + 4 + 3;
            exp_q.push_back(e);
        end
        addr_bus_n = ~7'd42;
        evt_line_n = 1'b0;
        repeat (10) @(negedge clk);
        addr_bus_n = ~7'd99;
        repeat (10) @(negedge clk);
        check("R6 held address after collision", int'(cap_addr), 42);
        evt_line_n = 1'b1;
        addr_bus_n = '1;
        repeat (6) @(negedge clk);
        check("R6 held address after release", int'(cap_addr), 42);

        // R6 re-arm after a single high cycle
        cfg_delay = 4'd1;
        fire(7'd17, 8, 1);
        fire(7'd64, 8, 6);
        check("R6 re-armed capture", int'(cap_addr), 64);

        // R7 column disabled
        run_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 recharge_n disabled", int'(recharge_n), 1);
        addr_bus_n = ~7'd9;
        evt_line_n = 1'b0;
        repeat (12) @(negedge clk);
        evt_line_n = 1'b1;
        addr_bus_n = '1;
        repeat (5) @(negedge clk);
        check("R7 address untouched while disabled", int'(cap_addr), 64);
        run_en = 1'b1;
        repeat (3) @(negedge clk);

        // R8 overrun without acknowledge
        auto_ack = 1'b0;
        cfg_delay = 4'd0;
        fire(7'd33, 8, 6);
        check("R8 overflow after first unacked", int'(overflow), 0);
        fire(7'd34, 8, 6);
        check("R8 overflow set", int'(overflow), 1);
        auto_ack = 1'b1;
        fire(7'd35, 8, 6);
        check("R8 overflow sticky", int'(overflow), 1);

        repeat (10) @(negedge clk);
        check("scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule